// File: doc/BRIEF.md
# Array Block Write-Guard and Wear-Zone Configuration

This unit sits beside the serial-bus slave of a byte-addressed non-volatile array. The array is split into sixteen equal blocks, and the unit keeps three small settings about them: the first block of a write-locked range, how many blocks that range holds, and which block is the high-wear block. The slave passes the unit every configuration command it decodes, meaning a write command whose first address byte has its top bit set. The unit updates its settings or loads a status pair that the slave shifts out on a later read. The settings are held in registers that reset to their factory values, which stands in for the non-volatile cells.

For ordinary array writes, the slave gives the starting byte address of a group of consecutive byte lanes. One cycle later the unit returns a mask that says which of those lanes may be committed. A locked byte is dropped without any error. The high-wear block can always be written, even when it lies inside the locked range. Once a range of one or more blocks has been locked, neither the range nor the high-wear block can be changed again.

Top module: `blkguard_cfg`

## Requirements
- R1: A command on `cfg_valid` is a configuration command only when `cfg_addr_hi[7]` is 1; otherwise it has no effect. Bits 4..1 of `cfg_addr_hi` carry a block number, and bits 0, 5 and 6 are ignored. In `cfg_cmd`, bits 7:6 select the action: 10 sets the locked range (count in bits 3..0), 11 reads the range, 00 sets the high-wear block, and 01 reads it. Bits 5..4 are ignored, and so are bits 3..0 for the actions that are not a range set.
- R2: After a synchronous reset, the range start is 15, the range count is 0 and the high-wear block is 15. `rd_valid` and `mask_valid` are 0.
- R3: A range read pulses `rd_valid` in the cycle after the command. It gives `rd_len`=2, `rd_byte0`={4'b1111, start} and `rd_byte1`={4'b1111, count}.
- R4: A high-wear read pulses `rd_valid` in the cycle after the command. It gives `rd_len`=1, `rd_byte0`={4'b1111, block} and `rd_byte1`=8'hFF.
- R5: While the count is 0, a range set stores the new start and count. This may be repeated any number of times while the count stays 0.
- R6: Once the count is non-zero, range sets and high-wear sets are still taken but leave every setting unchanged.
- R7: While the count is 0, a high-wear set stores the block number.
- R8: `wr_valid` with `wr_addr` produces `mask_valid` and `allow_mask` one cycle later. Bit i refers to address `wr_addr`+i modulo 8192, and its block is address bits 12..9. The bit is 0 only when that block lies in start..start+count-1 and is not the high-wear block.
- R9: Lanes that fall in the high-wear block are allowed even when that block lies inside the locked range.
- R10: When the lanes span a block boundary, each lane follows its own block, so a single group can mix allowed and refused lanes.
- R11: The locked range stops at block 15 and does not wrap to block 0. Lanes that wrap past address 0x1FFF map to block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Command byte pair presented this cycle |
| cfg_addr_hi | input | 8 | First address byte of the command |
| cfg_cmd | input | 8 | Third byte of the command (action and count) |
| rd_valid | output | 1 | Status pair loaded this cycle |
| rd_len | output | 2 | Number of status bytes to return |
| rd_byte0 | output | 8 | First status byte |
| rd_byte1 | output | 8 | Second status byte |
| wr_valid | input | 1 | Array write group presented this cycle |
| wr_addr | input | 13 | Byte address of lane 0 |
| mask_valid | output | 1 | Mask for the previous group is ready |
| allow_mask | output | 8 | Per-lane commit enable |

## Verification
The hardest state to reach is a locked range that contains the high-wear block while the range also borders other blocks. Getting there takes an exact sequence: the high-wear block must be moved first, the range must then be set with a non-zero count, and after that the lock must refuse every further change. The stimulus follows that order and reads the settings back after each refused command. It then aims lane groups straight at the block edges, at the high-wear block inside the range, and at the top of the array, where the range must stop while the lane addresses wrap.

// File: rtl/blkguard_pkg.sv
package blkguard_pkg;

  // Action selected by bits 7:6 of the command byte
  typedef enum logic [1:0] {
    ACT_WEAR_SET  = 2'b00,
    ACT_WEAR_RD   = 2'b01,
    ACT_RANGE_SET = 2'b10,
    ACT_RANGE_RD  = 2'b11
  } cfg_act_e;

  localparam logic [3:0] STATUS_PAD = 4'hF;

endpackage

// File: rtl/blkguard_regs.sv
module blkguard_regs
  import blkguard_pkg::*;
#(
  parameter int unsigned BLK_W     = 4,
  parameter int unsigned DEF_START = 15,
  parameter int unsigned DEF_COUNT = 0,
  parameter int unsigned DEF_WEAR  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_fire,
  input  cfg_act_e         cmd_act,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic [BLK_W-1:0] cmd_count,
  output logic [BLK_W-1:0] start_q,
  output logic [BLK_W-1:0] count_q,
  output logic [BLK_W-1:0] wear_q
);

  logic locked;
  assign locked = (count_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= BLK_W'(DEF_START);
      count_q <= BLK_W'(DEF_COUNT);
      wear_q  <= BLK_W'(DEF_WEAR);
    end else if (cmd_fire && !locked) begin
      case (cmd_act)
        ACT_RANGE_SET: begin
          start_q <= cmd_blk;
          count_q <= cmd_count;
        end
        ACT_WEAR_SET: wear_q <= cmd_blk;
        default: ;
      endcase
    end
  end

  AST_RANGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(start_q) && $stable(count_q)); // R6

  AST_WEAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(wear_q)); // R6

endmodule

// File: rtl/blkguard_readout.sv
module blkguard_readout
  import blkguard_pkg::*;
#(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_fire,
  input  cfg_act_e         cmd_act,
  input  logic [BLK_W-1:0] start_q,
  input  logic [BLK_W-1:0] count_q,
  input  logic [BLK_W-1:0] wear_q,
  output logic             rd_valid,
  output logic [1:0]       rd_len,
  output logic [7:0]       rd_byte0,
  output logic [7:0]       rd_byte1
);

  localparam int unsigned PAD_W = 8 - BLK_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_len   <= 2'd0;
      rd_byte0 <= 8'hFF;
      rd_byte1 <= 8'hFF;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_fire && cmd_act == ACT_RANGE_RD) begin
        rd_valid <= 1'b1;
        rd_len   <= 2'd2;
        rd_byte0 <= {{PAD_W{1'b1}}, start_q};
        rd_byte1 <= {{PAD_W{1'b1}}, count_q};
      end else if (cmd_fire && cmd_act == ACT_WEAR_RD) begin
        rd_valid <= 1'b1;
        rd_len   <= 2'd1;
        rd_byte0 <= {{PAD_W{1'b1}}, wear_q};
        rd_byte1 <= 8'hFF;
      end
    end
  end

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_byte0[7:4] == STATUS_PAD) && (rd_byte1[7:4] == STATUS_PAD)); // R3

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cmd_fire)); // R3

endmodule

// File: rtl/blkguard_mask.sv
module blkguard_mask #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BLK_W-1:0]  start_q,
  input  logic [BLK_W-1:0]  count_q,
  input  logic [BLK_W-1:0]  wear_q,
  output logic              mask_valid,
  output logic [LANES-1:0]  allow_mask
);

  logic [BLK_W:0]     range_end;
  logic [LANES-1:0]   allow_next;

  // exclusive end of the range; widened so it never wraps to block 0
  assign range_end = {1'b0, start_q} + {1'b0, count_q};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [BLK_W-1:0]  lane_blk;
    logic              in_range;
    assign lane_addr = wr_addr + ADDR_W'(g);
    assign lane_blk  = lane_addr[ADDR_W-1 -: BLK_W];
    assign in_range  = ({1'b0, lane_blk} >= {1'b0, start_q}) &&
                       ({1'b0, lane_blk} <  range_end);
    assign allow_next[g] = !in_range || (lane_blk == wear_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_valid <= 1'b0;
      allow_mask <= '0;
    end else begin
      mask_valid <= wr_valid;
      if (wr_valid) allow_mask <= allow_next;
    end
  end

  AST_MASK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    mask_valid |-> $past(wr_valid)); // R8

endmodule

// File: rtl/blkguard_cfg.sv
module blkguard_cfg
  import blkguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [7:0]        cfg_addr_hi,
  input  logic [7:0]        cfg_cmd,
  output logic              rd_valid,
  output logic [1:0]        rd_len,
  output logic [7:0]        rd_byte0,
  output logic [7:0]        rd_byte1,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mask_valid,
  output logic [LANES-1:0]  allow_mask
);

  logic             cmd_fire;
  cfg_act_e         cmd_act;
  logic [BLK_W-1:0] cmd_blk;
  logic [BLK_W-1:0] cmd_count;
  logic [BLK_W-1:0] start_q, count_q, wear_q;
  logic             unused_bits;

  assign cmd_fire  = cfg_valid && cfg_addr_hi[7];
  assign cmd_act   = cfg_act_e'(cfg_cmd[7:6]);
  assign cmd_blk   = cfg_addr_hi[BLK_W:1];
  assign cmd_count = cfg_cmd[BLK_W-1:0];
  assign unused_bits = ^{cfg_addr_hi[6:5], cfg_addr_hi[0], cfg_cmd[5:4]};

  blkguard_regs #(.BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd_act(cmd_act),
    .cmd_blk(cmd_blk), .cmd_count(cmd_count),
    .start_q(start_q), .count_q(count_q), .wear_q(wear_q)
  );

  blkguard_readout #(.BLK_W(BLK_W)) u_readout (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd_act(cmd_act),
    .start_q(start_q), .count_q(count_q), .wear_q(wear_q),
    .rd_valid(rd_valid), .rd_len(rd_len), .rd_byte0(rd_byte0), .rd_byte1(rd_byte1)
  );

  blkguard_mask #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LANES(LANES)) u_mask (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .start_q(start_q), .count_q(count_q), .wear_q(wear_q),
    .mask_valid(mask_valid), .allow_mask(allow_mask)
  );

  AST_OPEN_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    mask_valid && $past(count_q == '0) |-> (&allow_mask)); // R8

  AST_IGNORE_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_addr_hi[7] && !wr_valid) |=> !rd_valid && $stable(count_q)); // R1

endmodule

// File: tb/blkguard_cfg_tb.sv
module blkguard_cfg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // [38:37] kind (0 cmd, 1 cmd+readback, 2 mask), [36:24] addr/first byte,
  // [23:16] third byte, [15:0] expected
  localparam logic [38:0] VEC [NVEC] = '{
    {2'd1, 13'h0080, 8'hC0, 16'hFFF0},
    {2'd1, 13'h0080, 8'h40, 16'hFFFF},
    {2'd2, 13'h0000, 8'h00, 16'h00FF},
    {2'd0, 13'h00E7, 8'h05, 16'h0000},
    {2'd1, 13'h0080, 8'h40, 16'hF3FF},
    {2'd0, 13'h008E, 8'h80, 16'h0000},
    {2'd1, 13'h0080, 8'hC0, 16'hF7F0},
    {2'd0, 13'h0006, 8'h83, 16'h0000},
    {2'd1, 13'h0080, 8'hC0, 16'hF7F0},
    {2'd0, 13'h0084, 8'hB3, 16'h0000},
    {2'd1, 13'h0080, 8'hDA, 16'hF2F3},
    {2'd2, 13'h0400, 8'h00, 16'h0000},
    {2'd2, 13'h0600, 8'h00, 16'h00FF},
    {2'd2, 13'h09FC, 8'h00, 16'h00F0},
    {2'd2, 13'h03FD, 8'h00, 16'h0007},
    {2'd0, 13'h0092, 8'h85, 16'h0000},
    {2'd1, 13'h0080, 8'hC0, 16'hF2F3},
    {2'd0, 13'h0090, 8'h00, 16'h0000},
    {2'd1, 13'h0080, 8'h40, 16'hF3FF},
    {2'd2, 13'h0A00, 8'h00, 16'h00FF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [7:0]  cfg_addr_hi = 8'h00;
  logic [7:0]  cfg_cmd = 8'h00;
  logic        rd_valid;
  logic [1:0]  rd_len;
  logic [7:0]  rd_byte0, rd_byte1;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = 13'h0;
  logic        mask_valid;
  logic [7:0]  allow_mask;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkguard_cfg dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_addr_hi(cfg_addr_hi),
    .cfg_cmd(cfg_cmd), .rd_valid(rd_valid), .rd_len(rd_len),
    .rd_byte0(rd_byte0), .rd_byte1(rd_byte1), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .mask_valid(mask_valid), .allow_mask(allow_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] first, input logic [7:0] third);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr_hi = first; cfg_cmd = third;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic send_wr(input logic [12:0] a);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    do_reset();
    // R2: reset state of the outputs
    check("R2 rd_valid after reset", 32'(rd_valid), 32'd0);
    check("R2 mask_valid after reset", 32'(mask_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  kind;
      logic [12:0] a;
      logic [7:0]  b;
      logic [15:0] e;
      {kind, a, b, e} = VEC[i];
      if (kind == 2'd2) begin
        send_wr(a);
        check("R8 mask_valid", 32'(mask_valid), 32'd1);
        check("R8/R9/R10 allow_mask", 32'(allow_mask), 32'(e[7:0]));
      end else begin
        send_cmd(a[7:0], b);
        if (kind == 2'd1) begin
          check("R3/R4 rd_valid", 32'(rd_valid), 32'd1);
          check("R3/R4 rd_len", 32'(rd_len), b[7] ? 32'd2 : 32'd1);
          check("R3/R4 status bytes", 32'({rd_byte0, rd_byte1}), 32'(e));
        end else if (!a[7]) begin
          check("R1 plain command ignored", 32'(rd_valid), 32'd0);
        end
      end
    end

    // R3: status pair pulse lasts one cycle
    @(negedge clk);
    check("R3 rd_valid drops", 32'(rd_valid), 32'd0);

    // R2: reset restores factory settings
    do_reset();
    send_cmd(8'h80, 8'hC0);
    check("R2 default range", 32'({rd_byte0, rd_byte1}), 32'h0000FFF0);
    send_cmd(8'h80, 8'h40);
    check("R2 default wear block", 32'(rd_byte0), 32'h000000FF);

    // R5/R11: range 14..18 clips at block 15, wear block 15 stays open
    send_cmd(8'h9C, 8'h85);
    send_cmd(8'h80, 8'hC0);
    check("R5 range stored", 32'({rd_byte0, rd_byte1}), 32'h0000FEF5);
    send_wr(13'h1BFC);
    check("R10 block 13/14 edge", 32'(allow_mask), 32'h0F);
    send_wr(13'h1DFE);
    check("R9 wear block inside range", 32'(allow_mask), 32'hFC);
    send_wr(13'h1FFC);
    check("R11 no wrap of range, lanes wrap to block 0", 32'(allow_mask), 32'hFF);

    // R7: wear set works while unlocked (after reset)
    do_reset();
    send_cmd(8'hAA, 8'h3F);
    send_cmd(8'h80, 8'h40);
    check("R7 wear block set to 5", 32'(rd_byte0), 32'h000000F5);

    // R6: locked, wear move refused
    send_cmd(8'h82, 8'h81);
    send_cmd(8'h8C, 8'h00);
    send_cmd(8'h80, 8'h40);
    check("R6 wear block frozen", 32'(rd_byte0), 32'h000000F5);
    send_wr(13'h0200);
    check("R6 block 1 locked", 32'(allow_mask), 32'h00);

    finish_up();
  end

endmodule